// File: doc/BRIEF.md
# Small FIFO with Occupancy Flags

A single-clock first-in first-out buffer for short queues between two pipeline stages. A producer pushes a word by raising the write enable with the word on the write data bus. A consumer pops the oldest word by raising the read enable, and the word appears on a registered output one clock later. The depth is a power of two set by the address width. The default is four entries of eight bits.

Four status outputs are decoded from an internal occupancy count. They are empty, full, at-least-one-available and at-least-two-available. The last of these lets a consumer that needs a pair of words start fetching them without stalling between the two. A write and a read can happen in the same clock at every fill level. At empty only the write takes effect. At full only the read takes effect. At any other level both take effect and the count is unchanged.

Top module: `occ_fifo`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the occupancy, both pointers and `rd_data` are cleared. After reset `empty` is 1, `full`, `one_avail` and `two_avail` are 0, and `rd_data` is 0.
- R2: The depth is 2^ADDR_W entries. With the default ADDR_W = 2, `full` rises only after the fourth accepted write into an empty FIFO.
- R3: `one_avail` is 1 exactly when at least one entry is stored. `two_avail` is 1 exactly when at least two entries are stored. Both remain 1 while `full` is 1.
- R4: A write alone while `full` is 1 is dropped. The flags and the stored words are unchanged, which a later read-out shows.
- R5: A read alone while `empty` is 1 leaves the occupancy unchanged and leaves `rd_data` at its previous value. A write in the same cycle is still accepted, which leaves exactly one entry.
- R6: A read and a write in the same cycle with one entry stored return the stored entry and keep the new word. The FIFO is left holding one entry.
- R7: A read and a write in the same cycle while full perform only the read. The write is dropped and the occupancy becomes one less than the depth.
- R8: A read and a write in the same cycle with depth-minus-one entries stored perform both. The occupancy stays the same and the new word becomes the last to be read.
- R9: Words are read out in the order they were accepted. Each word is on `rd_data` after the rising edge that samples its read enable.
- R10: `rd_data` holds its last value in every cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | DATA_W | Registered popped word |
| empty | output | 1 | No entry stored |
| full | output | 1 | All 2^ADDR_W entries stored |
| one_avail | output | 1 | At least one entry stored |
| two_avail | output | 1 | At least two entries stored |

## Verification
The hardest cases are the same-cycle push and pop at the two boundary fill levels. At full, the push must be dropped while the pop proceeds. At depth minus one, both must land, and the new word must go in behind the three older ones. The bench reaches these by filling the FIFO with four directed pushes and issuing a combined operation. It then issues a second combined operation at depth minus one and drains everything. The drain order shows which words were kept. A dropped push at full is also shown only through the later drain, since no flag changes.

// File: rtl/occ_fifo_pkg.sv
// Package: shared types for the occupancy-flag FIFO.
// Assumes: nothing beyond a single clock domain.
package occ_fifo_pkg;

    // Status flags decoded from the occupancy count.
    typedef struct packed {
        logic empty;
        logic full;
        logic one;
        logic two;
    } occ_flags_t;

endpackage

// File: rtl/occ_fifo_ctrl.sv
// Module: pointer and occupancy control.
// Decides which of the requested push and pop are accepted from the
// current count, then advances the pointers and the count.
// Assumes: DEPTH = 2**ADDR_W, and pointers wrap naturally at ADDR_W bits.
module occ_fifo_ctrl #(
    parameter int ADDR_W = 2,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic [ADDR_W-1:0] wptr,
    output logic [ADDR_W-1:0] rptr,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1) << ADDR_W;

    // Purpose: accept requests using the count before this edge.
    always_comb begin
        rd_ok = rd_en && (count != '0);
        wr_ok = wr_en && (count != DEPTH_C);
    end

    // Purpose: advance pointers and count on accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (rd_ok) rptr <= rptr + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/occ_fifo_mem.sv
// Module: word storage with a registered read port.
// Writes land at wptr. An accepted read copies the word at rptr into
// the output register, which otherwise holds its value.
// Assumes: wr_ok and rd_ok are already qualified by occupancy.
module occ_fifo_mem #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] wptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_ok,
    input  logic [ADDR_W-1:0] rptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] store [DEPTH];

    // Purpose: one write-enabled register per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_ok && (wptr == ADDR_W'(g))) store[g] <= wr_data;
        end
    end

    // Purpose: registered read data, held when no read is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_ok) rd_data <= store[rptr];
    end
endmodule

// File: rtl/occ_fifo_flags.sv
// Module: decodes the four status flags from the occupancy count.
// The decode is purely combinational.
// Assumes: count never exceeds 2**ADDR_W.
module occ_fifo_flags #(
    parameter int ADDR_W = 2,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic [CNT_W-1:0]         count,
    output occ_fifo_pkg::occ_flags_t flags
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1) << ADDR_W;

    // Purpose: compare the count against the fixed thresholds.
    always_comb begin
        flags.empty = (count == '0);
        flags.full  = (count == DEPTH_C);
        flags.one   = (count >= CNT_W'(1));
        flags.two   = (count >= CNT_W'(2));
    end
endmodule

// File: rtl/occ_fifo.sv
// Module: single-clock FIFO with empty, full, one-available and
// two-available flags.
// A push and a pop in the same cycle: at empty only the push is taken,
// at full only the pop, otherwise both are taken.
// Assumes: synchronous active-low reset, ADDR_W >= 1.
module occ_fifo #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              one_avail,
    output logic              two_avail
);
    localparam int CNT_W = ADDR_W + 1;

    logic              wr_ok, rd_ok;
    logic [ADDR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0]  count;
    occ_fifo_pkg::occ_flags_t flags;

    occ_fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .wptr(wptr), .rptr(rptr),
        .count(count)
    );

    occ_fifo_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wptr(wptr),
        .wr_data(wr_data), .rd_ok(rd_ok), .rptr(rptr), .rd_data(rd_data)
    );

    occ_fifo_flags #(.ADDR_W(ADDR_W)) u_flags (
        .count(count), .flags(flags)
    );

    // Purpose: drive the status ports from the decoded flags.
    always_comb begin
        empty     = flags.empty;
        full      = flags.full;
        one_avail = flags.one;
        two_avail = flags.two;
    end
endmodule

// File: rtl/occ_fifo_chk.sv
// Module: assertion checker for occ_fifo, attached by bind.
// Observes only the ports of the FIFO.
module occ_fifo_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              empty,
    input logic              full,
    input logic              one_avail,
    input logic              two_avail
);
    // R1: a reset edge leaves the FIFO empty with the other flags low
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !one_avail && !two_avail && rd_data == '0));

    // R3: flag consistency
    a_r3_one_vs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        one_avail == !empty);
    a_r3_two_implies_one: assert property (@(posedge clk) disable iff (!rst_n)
        two_avail |-> one_avail);
    a_r3_full_keeps_two: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> two_avail);

    // R4: a lone push at full changes nothing visible
    a_r4_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && $stable(rd_data)));

    // R5: a lone pop at empty changes nothing visible
    a_r5_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data)));

    // R5: push and pop together at empty leaves exactly one entry
    a_r5_empty_both_one: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && wr_en) |=> (one_avail && !two_avail && $stable(rd_data)));

    // R7: push and pop together at full leaves the FIFO not full
    a_r7_full_both_pop_only: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_en && wr_en) |=> (!full && one_avail));

    // R10: no pop request, no change of read data
    a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind occ_fifo occ_fifo_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .full(full),
    .one_avail(one_avail), .two_avail(two_avail)
);

// File: tb/sim_occ_fifo.sv
`timescale 1ns/1ps
// Bench: directed scenarios for occ_fifo, one task each.
module sim_occ_fifo;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              empty, full, one_avail, two_avail;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    occ_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full),
        .one_avail(one_avail), .two_avail(two_avail)
    );

    // Compare one value and count the check.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FIFO FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check all four flags, with the expected fill level.
    task automatic chk_flags(input string req, input int n);
        chk({req, " empty"}, int'(empty), int'(n == 0));
        chk({req, " full"},  int'(full),  int'(n == 4));
        chk({req, " one"},   int'(one_avail), int'(n >= 1));
        chk({req, " two"},   int'(two_avail), int'(n >= 2));
    endtask

    // One cycle of stimulus, driven and sampled at falling edges.
    task automatic op(input logic we, input logic re, input logic [7:0] d);
        @(negedge clk);
        wr_en = we; rd_en = re; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_flags("R1", 0);
        chk("R1 rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_fill_and_full_write();
        for (int i = 0; i < 4; i++) begin
            op(1'b1, 1'b0, 8'h70 + 8'(i));
            chk_flags("R2 R3 fill", i + 1);
        end
        op(1'b1, 1'b0, 8'hAB);
        chk_flags("R4 push at full", 4);
        for (int i = 0; i < 4; i++) begin
            op(1'b0, 1'b1, 8'h00);
            chk("R9 R4 order", int'(rd_data), 'h70 + i);
            chk_flags("R3 drain", 3 - i);
        end
    endtask

    task automatic t_empty_ops();
        op(1'b0, 1'b1, 8'h00);
        chk_flags("R5 pop at empty", 0);
        chk("R5 R10 rd_data held", int'(rd_data), 'h73);
        op(1'b1, 1'b1, 8'h80);
        chk_flags("R5 both at empty", 1);
        chk("R5 rd_data held", int'(rd_data), 'h73);
        op(1'b0, 1'b1, 8'h00);
        chk("R5 pushed word", int'(rd_data), 'h80);
        chk_flags("R5 drained", 0);
    endtask

    task automatic t_one_entry_both();
        op(1'b1, 1'b0, 8'h90);
        op(1'b1, 1'b1, 8'hA0);
        chk("R6 old word out", int'(rd_data), 'h90);
        chk_flags("R6 count one", 1);
        op(1'b0, 1'b1, 8'h00);
        chk("R6 new word kept", int'(rd_data), 'hA0);
        chk_flags("R6 drained", 0);
    endtask

    task automatic t_full_both();
        for (int i = 0; i < 4; i++) op(1'b1, 1'b0, 8'h10 + 8'(i));
        chk_flags("R2 full", 4);
        op(1'b1, 1'b1, 8'h20);
        chk("R7 read at full", int'(rd_data), 'h10);
        chk_flags("R7 count three", 3);
        op(1'b1, 1'b1, 8'h21);
        chk("R8 read at three", int'(rd_data), 'h11);
        chk_flags("R8 count three", 3);
        op(1'b0, 1'b1, 8'h00);
        chk("R8 drain a", int'(rd_data), 'h12);
        op(1'b0, 1'b1, 8'h00);
        chk("R8 drain b", int'(rd_data), 'h13);
        op(1'b0, 1'b1, 8'h00);
        chk("R8 R7 tail word", int'(rd_data), 'h21);
        chk_flags("R8 drained", 0);
    endtask

    task automatic t_hold();
        op(1'b1, 1'b0, 8'h5C);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 hold", int'(rd_data), 'h21);
        end
        op(1'b0, 1'b1, 8'h00);
        chk("R9 R10 next read", int'(rd_data), 'h5C);
    endtask

    initial begin
        t_reset();
        t_fill_and_full_write();
        t_empty_ops();
        t_one_entry_both();
        t_full_both();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FIFO FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule